// File: doc/BRIEF.md
# PWM Two-Level Interrupt Request Controller

This block collects the cycle-start strobes of a group of PWM channels and turns them into two levels of interrupt request. Every channel owns a sticky request flag that rises when its channel begins a new period (the moment its shadow registers take fresh values). A raised channel flag tells software that the channel's period and width registers may be rewritten. Only software clears a channel flag, with a write-one-to-clear mask.

Above the channel flags sits a single module request, which is the line the CPU sees. A channel event reaches the module request only when both that channel's enable and the common module enable are set. The module request is held by a two-state machine. It leaves state `MOD_PEND` for `MOD_IDLE` on the acknowledge pulse that marks entry into the service routine, whatever the channel flags hold. It returns to `MOD_PEND` whenever a new enabled event arrives, including during the service routine or in the very cycle of the acknowledge. The CPU interrupt output is the module request passed through one more register.

Module-request states and transitions: `MOD_IDLE` → `MOD_PEND` on an enabled event (`T_RAISE`). `MOD_PEND` → `MOD_IDLE` on an acknowledge with no enabled event in the same cycle (`T_SERVE`). `MOD_PEND` stays in `MOD_PEND` on an acknowledge that coincides with an enabled event (`T_REARM`). Every other input leaves the state unchanged (`T_HOLD`).

Top module: `pwm_irq_ctrl`

## Requirements
- R1: After reset, all channel flags, all channel enables, the module enable, the module request and the CPU interrupt line are 0.
- R2: A strobe on `cyc_start[i]` makes `ch_flag[i]` read 1 from the following clock on, whatever the enables hold.
- R3: A channel flag stays at 1 until a cycle with `clr_wr`=1 and `clr_mask[i]`=1. An acknowledge, mask bits of other channels, and the passage of time do not clear it.
- R4: When a clear of channel i and a strobe on channel i fall in the same cycle, `ch_flag[i]` reads 1 afterwards.
- R5: `mod_flag` rises in the clock after a cycle in which some `cyc_start[i]` and `ch_ie[i]` are both 1 and `mod_ie` is 1, using the enable values held in that cycle. Strobes on disabled channels, or any strobe while `mod_ie`=0, leave `mod_flag` at 0.
- R6: An `irq_ack` pulse with no enabled event in the same cycle makes `mod_flag` 0 in the following clock, even when every channel flag is 1.
- R7: An enabled event after the acknowledge, while the channel flags are still set, raises `mod_flag` again.
- R8: An enabled event in the same cycle as `irq_ack` leaves `mod_flag` at 1.
- R9: `irq` equals the value `mod_flag` had one clock earlier.
- R10: A cycle with `cfg_wr`=1 loads `cfg_ch_ie` into `ch_ie` and `cfg_mod_ie` into `mod_ie` for the following clock. Without `cfg_wr`, both enable registers hold their values.
- R11: Clearing channel flags has no effect on `mod_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | NUM_CH | Per-channel strobe at the start of a new PWM period |
| cfg_wr | input | 1 | Write strobe for the enable registers |
| cfg_ch_ie | input | NUM_CH | New per-channel enables |
| cfg_mod_ie | input | 1 | New module enable |
| clr_wr | input | 1 | Write strobe for clearing channel flags |
| clr_mask | input | NUM_CH | Write-one-to-clear mask for the channel flags |
| irq_ack | input | 1 | Acknowledge pulse on entry into the service routine |
| ch_flag | output | NUM_CH | Channel request flags for readback |
| ch_ie | output | NUM_CH | Channel enables for readback |
| mod_ie | output | 1 | Module enable for readback |
| mod_flag | output | 1 | Module request flag for readback |
| irq | output | 1 | Registered interrupt line to the CPU |

## Verification
The bench builds the block with its default of four channels. With four channels, all 16 strobe patterns, all 16 channel-enable vectors and both module-enable settings can be crossed in full, which is 512 cases. Each case is checked for the channel flags, the gated module request and the delayed interrupt line. Directed sequences cover the collisions (clear against set, acknowledge against an event), re-arming during service, and the independence of the module request from channel clears.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

    // Module-level request state
    typedef enum logic [0:0] {
        MOD_IDLE = 1'b0,
        MOD_PEND = 1'b1
    } mod_state_e;

    // Named transitions of the module-level request
    typedef enum logic [1:0] {
        T_HOLD  = 2'd0,
        T_RAISE = 2'd1,
        T_SERVE = 2'd2,
        T_REARM = 2'd3
    } mod_trans_e;

endpackage

// File: rtl/pwm_irq_chan_flags.sv
module pwm_irq_chan_flags #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cyc_start,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] flags
);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic clr_hit;
        assign clr_hit = clr_wr & clr_mask[gi];

        // Set has priority over a coinciding clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[gi] <= 1'b0;
            end else if (cyc_start[gi]) begin
                flags[gi] <= 1'b1;
            end else if (clr_hit) begin
                flags[gi] <= 1'b0;
            end
        end

        // R2, R4: a strobe always leaves the flag set
        a_r2_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
            cyc_start[gi] |=> flags[gi]);

        // R3: only a matching software clear drops the flag
        a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[gi] && !(clr_wr && clr_mask[gi])) |=> flags[gi]);

        // R2: the flag never rises without a strobe
        a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[gi] && !cyc_start[gi]) |=> !flags[gi]);
    end

endmodule

// File: rtl/pwm_irq_cfg.sv
module pwm_irq_cfg #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [NUM_CH-1:0] cfg_ch_ie,
    input  logic              cfg_mod_ie,
    input  logic [NUM_CH-1:0] cyc_start,
    output logic [NUM_CH-1:0] ch_ie,
    output logic              mod_ie,
    output logic              enabled_event
);

    logic [NUM_CH-1:0] gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_ie  <= '0;
            mod_ie <= 1'b0;
        end else if (cfg_wr) begin
            ch_ie  <= cfg_ch_ie;
            mod_ie <= cfg_mod_ie;
        end
    end

    // Two-level gating: per-channel enable, then common enable
    always_comb begin
        gated         = cyc_start & ch_ie;
        enabled_event = mod_ie & (|gated);
    end

    // R10: a write loads both enable registers
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ch_ie == $past(cfg_ch_ie)) && (mod_ie == $past(cfg_mod_ie)));

    // R10: no write, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(ch_ie) && $stable(mod_ie));

endmodule

// File: rtl/pwm_irq_mod_fsm.sv
module pwm_irq_mod_fsm
    import pwm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enabled_event,
    input  logic irq_ack,
    output logic mod_flag,
    output logic irq
);

    mod_state_e state_q, state_d;
    mod_trans_e trans;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        trans   = T_HOLD;
        unique case (state_q)
            MOD_IDLE: begin
                if (enabled_event) begin
                    state_d = MOD_PEND;
                    trans   = T_RAISE;
                end
            end
            MOD_PEND: begin
                if (irq_ack && enabled_event) begin
                    state_d = MOD_PEND;
                    trans   = T_REARM;
                end else if (irq_ack) begin
                    state_d = MOD_IDLE;
                    trans   = T_SERVE;
                end
            end
            default: state_d = MOD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MOD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: readback flag and registered CPU line
    assign mod_flag = (state_q == MOD_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (state_q == MOD_PEND);
        end
    end

    // R5, R7, R8: an enabled event always leaves the request pending
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        enabled_event |=> mod_flag);

    // R6: acknowledge without an event drops the request
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !enabled_event) |=> !mod_flag);

    // R5: the request only rises on an enabled event
    a_r5_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_flag && !enabled_event) |=> !mod_flag);

    // R11: without acknowledge the request does not fall
    a_r11_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_flag && !irq_ack) |=> mod_flag);

    // R9: CPU line trails the request by one clock
    a_r9_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(mod_flag)));

    // The T_SERVE transition is taken only from a pending state
    a_r6_serve_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (trans == T_SERVE) |-> (state_q == MOD_PEND) && irq_ack);

endmodule

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cyc_start,
    input  logic              cfg_wr,
    input  logic [NUM_CH-1:0] cfg_ch_ie,
    input  logic              cfg_mod_ie,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic              irq_ack,
    output logic [NUM_CH-1:0] ch_flag,
    output logic [NUM_CH-1:0] ch_ie,
    output logic              mod_ie,
    output logic              mod_flag,
    output logic              irq
);

    logic enabled_event;

    pwm_irq_chan_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_start(cyc_start),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags    (ch_flag)
    );

    pwm_irq_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_ch_ie    (cfg_ch_ie),
        .cfg_mod_ie   (cfg_mod_ie),
        .cyc_start    (cyc_start),
        .ch_ie        (ch_ie),
        .mod_ie       (mod_ie),
        .enabled_event(enabled_event)
    );

    pwm_irq_mod_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enabled_event(enabled_event),
        .irq_ack      (irq_ack),
        .mod_flag     (mod_flag),
        .irq          (irq)
    );

    // R1: everything quiet in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (ch_flag == '0) && !mod_flag && !irq && (ch_ie == '0) && !mod_ie);

endmodule

// File: tb/test_pwm_irq_ctrl.sv
`timescale 1ns/1ps
module test_pwm_irq_ctrl;

    localparam int NUM_CH = 4;
    localparam int NPAT   = 1 << NUM_CH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] cyc_start = '0;
    logic              cfg_wr = 1'b0;
    logic [NUM_CH-1:0] cfg_ch_ie = '0;
    logic              cfg_mod_ie = 1'b0;
    logic              clr_wr = 1'b0;
    logic [NUM_CH-1:0] clr_mask = '0;
    logic              irq_ack = 1'b0;
    logic [NUM_CH-1:0] ch_flag;
    logic [NUM_CH-1:0] ch_ie;
    logic              mod_ie;
    logic              mod_flag;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_irq_ctrl #(.NUM_CH(NUM_CH)) i_pwm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .cfg_wr(cfg_wr), .cfg_ch_ie(cfg_ch_ie), .cfg_mod_ie(cfg_mod_ie),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_ack(irq_ack),
        .ch_flag(ch_flag), .ch_ie(ch_ie), .mod_ie(mod_ie),
        .mod_flag(mod_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs are set before a call, registered at the rising edge,
    // and results are read at the following falling edge.
    task automatic step();
        @(negedge clk);
        cyc_start = '0;
        cfg_wr    = 1'b0;
        clr_wr    = 1'b0;
        clr_mask  = '0;
        irq_ack   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ch_flag", 32'(ch_flag), 0);
        check("R1 mod_flag", 32'(mod_flag), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 enables", 32'({mod_ie, ch_ie}), 0);
        rst_n = 1'b1;
        step();
        check("R1 after release", 32'({irq, mod_flag, ch_flag}), 0);

        // Exhaustive sweep: strobe pattern x channel enables x module enable
        for (int me = 0; me < 2; me++) begin
            for (int ie = 0; ie < NPAT; ie++) begin
                for (int pat = 0; pat < NPAT; pat++) begin
                    logic exp_mod;
                    exp_mod = (me == 1) && ((pat & ie) != 0);
                    cfg_wr = 1'b1; cfg_ch_ie = NUM_CH'(ie); cfg_mod_ie = me[0];
                    clr_wr = 1'b1; clr_mask = '1; irq_ack = 1'b1;
                    step();
                    step();
                    check("R10 enable readback", 32'({mod_ie, ch_ie}), 32'((me << NUM_CH) | ie));
                    check("R6 cleared before case", 32'(mod_flag), 0);
                    cyc_start = NUM_CH'(pat);
                    step();
                    check("R2 flags follow strobes", 32'(ch_flag), 32'(pat));
                    check("R5 gated module request", 32'(mod_flag), 32'(exp_mod));
                    step();
                    check("R9 irq trails request", 32'(irq), 32'(exp_mod));
                    check("R3 flags held", 32'(ch_flag), 32'(pat));
                end
            end
        end

        // Clean slate with everything enabled
        cfg_wr = 1'b1; cfg_ch_ie = '1; cfg_mod_ie = 1'b1;
        clr_wr = 1'b1; clr_mask = '1; irq_ack = 1'b1;
        step();
        step();

        // R3: sticky against ack and foreign masks; R11: clear leaves module request
        cyc_start = 4'b0100;
        step();
        clr_wr = 1'b1; clr_mask = 4'b1011;
        step();
        check("R3 foreign mask", 32'(ch_flag), 32'h4);
        check("R11 clear keeps request", 32'(mod_flag), 1);
        clr_wr = 1'b1; clr_mask = 4'b0100;
        step();
        check("R3 own mask clears", 32'(ch_flag), 0);
        check("R11 request after full clear", 32'(mod_flag), 1);
        repeat (20) step();
        check("R11 request persists", 32'(mod_flag), 1);

        // R6: acknowledge with all channel flags set
        cyc_start = '1;
        step();
        irq_ack = 1'b1;
        step();
        check("R6 ack clears request", 32'(mod_flag), 0);
        check("R3 ack leaves flags", 32'(ch_flag), 32'hF);
        step();
        check("R9 irq falls", 32'(irq), 0);

        // R7: new event during service re-arms
        cyc_start = 4'b1000;
        step();
        check("R7 rearm", 32'(mod_flag), 1);
        step();
        check("R7 irq rearmed", 32'(irq), 1);

        // R8: event coinciding with ack
        irq_ack = 1'b1; cyc_start = 4'b0001;
        step();
        check("R8 event beats ack", 32'(mod_flag), 1);

        // R4: clear coinciding with set
        clr_wr = 1'b1; clr_mask = '1;
        step();
        check("R4 precondition", 32'(ch_flag), 0);
        clr_wr = 1'b1; clr_mask = 4'b0010; cyc_start = 4'b0010;
        step();
        check("R4 set beats clear", 32'(ch_flag), 32'h2);

        // R5: disabled channel does not reach module request
        cfg_wr = 1'b1; cfg_ch_ie = 4'b0001; cfg_mod_ie = 1'b1; irq_ack = 1'b1;
        step();
        cyc_start = 4'b1110;
        step();
        check("R5 disabled channels", 32'(mod_flag), 0);
        check("R2 flags without enable", 32'(ch_flag), 32'hE);

        // R10: enables hold without a write
        cfg_ch_ie = 4'b1111; cfg_mod_ie = 1'b0;
        step();
        check("R10 hold", 32'({mod_ie, ch_ie}), 32'h11);

        finish_run();
    end

endmodule